// File: doc/BRIEF.md
# Sixteen-Pin I/O Expander with Edge-Latched Interrupts

The block gives a host sixteen auxiliary pins behind a small bank of memory-mapped registers. Each pin can be driven as an output or left as an input, and its synchronized level can be read back at any time. Pins that drive resets for external boards, such as a disc loader or a modem card, are ordinary outputs under host control.

Four adjacent pins (by default pins 12 to 15) can also serve as interrupt sources, for instance a remote-control receiver or a modem request line. On each of them a chosen edge, rising or falling, sets a sticky status bit once that pin's interrupt is enabled. The host clears a status bit by writing a one to it. A single active-high interrupt line is raised while any enabled status bit is set.

Register addresses (3-bit `addr`): 0 direction (bit n = 1 drives pin n), 1 output value, 2 synchronized input levels (read only), 3 interrupt enable (bits 3:0), 4 edge select (bits 3:0, 1 = rising, 0 = falling), 5 interrupt status (bits 3:0, write 1 to clear). Bit k of registers 3 to 5 belongs to pin 12+k. Addresses 6 and 7 read as zero.

Top module: `aux_port_expander`

## Requirements
- R1: After reset, `pin_oe`, `pin_out`, the enable, edge-select and status registers are all zero and `irq` is low.
- R2: A write to address 0 appears on `pin_oe` and a write to address 1 appears on `pin_out` on the clock edge that performs the write; both read back at their addresses.
- R3: Address 2 returns `pin_in` through a two-stage synchronizer: a change of `pin_in` is visible after the second rising clock edge and not after the first.
- R4: With bit k enabled at address 3, an edge of pin 12+k in the polarity chosen by bit k of address 4 (1 rising, 0 falling) sets status bit k on the third rising clock edge after the pin changes.
- R5: An edge of the opposite polarity, or any edge on a pin whose enable bit is 0, leaves the status bits at zero.
- R6: Writing address 5 clears each status bit whose data bit is 1 and leaves the bits written with 0 unchanged; status bits hold until cleared.
- R7: When an edge event and a clearing write to the same status bit fall on the same clock edge, the bit ends up set.
- R8: `irq` is high exactly while some status bit and its enable bit are both 1; clearing an enable bit drops `irq` without clearing the status bit.
- R9: Addresses 6 and 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| pin_in | input | 16 | Sampled pin levels |
| pin_out | output | 16 | Driven pin levels |
| pin_oe | output | 16 | Per-pin output enable |
| irq | output | 1 | Combined interrupt to the host |

## Verification
The edge detector and the host's write-one-to-clear access can act on the same status bit in the same cycle. The bench changes an interrupt pin and times a clearing write so that it lands on exactly the third rising edge after the change, where the event is recorded. It then judges that the bit reads as set and `irq` stays high. A clearing write alone, one cycle away from any edge, is checked to leave the bit at zero.

// File: rtl/aux_port_expander.sv
module aux_port_expander #(
  parameter int NPIN     = 16,
  parameter int NIRQ     = 4,
  parameter int IRQ_BASE = 12,
  parameter int AW       = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [NPIN-1:0] wdata,
  output logic [NPIN-1:0] rdata,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe,
  output logic            irq
);
  localparam logic [AW-1:0] A_DIR  = AW'(0);
  localparam logic [AW-1:0] A_OUT  = AW'(1);
  localparam logic [AW-1:0] A_IN   = AW'(2);
  localparam logic [AW-1:0] A_EN   = AW'(3);
  localparam logic [AW-1:0] A_EDGE = AW'(4);
  localparam logic [AW-1:0] A_STAT = AW'(5);

  logic [NPIN-1:0] dir_q, out_q, sync1_q, sync2_q;
  logic [NIRQ-1:0] prev_q, en_q, rise_q, stat_q;
  logic [NIRQ-1:0] level, hit, clr;

  assign level = sync2_q[IRQ_BASE +: NIRQ];
  assign hit   = en_q & ((rise_q & level & ~prev_q) | (~rise_q & ~level & prev_q));
  assign clr   = (wr_en && addr == A_STAT) ? wdata[NIRQ-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      out_q   <= '0;
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
      en_q    <= '0;
      rise_q  <= '0;
      stat_q  <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      prev_q  <= level;
      stat_q  <= (stat_q & ~clr) | hit;
      if (wr_en) begin
        case (addr)
          A_DIR:   dir_q  <= wdata;
          A_OUT:   out_q  <= wdata;
          A_EN:    en_q   <= wdata[NIRQ-1:0];
          A_EDGE:  rise_q <= wdata[NIRQ-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_DIR:   rdata = dir_q;
      A_OUT:   rdata = out_q;
      A_IN:    rdata = sync2_q;
      A_EN:    rdata[NIRQ-1:0] = en_q;
      A_EDGE:  rdata[NIRQ-1:0] = rise_q;
      A_STAT:  rdata[NIRQ-1:0] = stat_q;
      default: rdata = '0;
    endcase
  end

  assign pin_oe  = dir_q;
  assign pin_out = out_q;
  assign irq     = |(stat_q & en_q);
endmodule

// File: rtl/aux_port_expander_chk.sv
module aux_port_expander_chk #(
  parameter int NPIN = 16,
  parameter int NIRQ = 4,
  parameter int AW   = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [AW-1:0]   addr,
  input logic [NPIN-1:0] wdata,
  input logic [NPIN-1:0] pin_oe,
  input logic            irq,
  input logic [NIRQ-1:0] stat_q,
  input logic [NIRQ-1:0] en_q
);
  localparam logic [AW-1:0] A_DIR  = AW'(0);
  localparam logic [AW-1:0] A_STAT = AW'(5);

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (stat_q == '0 && en_q == '0 && pin_oe == '0 && !irq));

  assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_DIR) |=> pin_oe == $past(wdata));

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == A_STAT) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  assert_irq_needs_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat_q != '0 && en_q != '0));

  assert_irq_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & en_q) != '0) |-> irq);
endmodule

bind aux_port_expander aux_port_expander_chk #(.NPIN(NPIN), .NIRQ(NIRQ), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .pin_oe(pin_oe), .irq(irq), .stat_q(stat_q), .en_q(en_q)
);

// File: tb/test_aux_port_expander.sv
module test_aux_port_expander;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [2:0]  addr = 0;
  logic [15:0] wdata = 0;
  logic [15:0] rdata, pin_out, pin_oe;
  logic [15:0] pin_in = 0;
  logic        irq;
  int checks = 0, fails = 0;
  bit done = 0;

  aux_port_expander i_aux_port_expander (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic [15:0] v;

  initial begin
    wait_n(3);
    // R1 reset state
    check("R1 pin_oe", pin_oe, 16'h0);
    check("R1 pin_out", pin_out, 16'h0);
    check("R1 irq", {15'h0, irq}, 16'h0);
    for (int a = 3; a <= 5; a++) begin
      rd(3'(a), v);
      check("R1 reg", v, 16'h0);
    end
    rst_n = 1;
    wait_n(1);

    // R2 direction and output sweep
    for (int i = 0; i < 16; i++) begin
      logic [15:0] d, o;
      d = 16'(i * 16'h1357) ^ 16'(1 << i);
      o = ~16'(i * 16'h0f1d);
      wr(3'd0, d);
      wr(3'd1, o);
      check("R2 pin_oe", pin_oe, d);
      check("R2 pin_out", pin_out, o);
      rd(3'd0, v); check("R2 dir readback", v, d);
      rd(3'd1, v); check("R2 out readback", v, o);
    end

    // R3 synchronizer latency, walking patterns
    for (int i = 0; i < 17; i++) begin
      logic [15:0] old, nw;
      rd(3'd2, old);
      nw = (i == 16) ? 16'h0 : (16'(1 << i) | 16'(i * 16'h0101));
      pin_in = nw;
      wait_n(1);
      rd(3'd2, v); check("R3 not yet after one edge", v, old);
      wait_n(1);
      rd(3'd2, v); check("R3 visible after two edges", v, nw);
    end

    // R4/R5 edge sweep over pin, polarity and enable
    for (int k = 0; k < 4; k++)
      for (int rise = 0; rise < 2; rise++)
        for (int en = 0; en < 2; en++) begin
          logic [3:0] expb;
          wr(3'd3, 16'(en << k));
          wr(3'd4, 16'(rise << k));
          pin_in[12+k] = (rise == 0);
          wait_n(3);
          wr(3'd5, 16'hF);
          wait_n(1);
          pin_in[12+k] = (rise == 1);
          wait_n(2);
          rd(3'd5, v); check("R4 not set before third edge", v, 16'h0);
          wait_n(1);
          expb = en ? 4'(1 << k) : 4'h0;
          rd(3'd5, v); check(en ? "R4 selected edge sets status" : "R5 disabled pin ignored", v, {12'h0, expb});
          check("R8 irq on event", {15'h0, irq}, {15'h0, (en == 1)});
          wr(3'd5, 16'hF);
          pin_in[12+k] = (rise == 0);
          wait_n(4);
          rd(3'd5, v); check("R5 opposite edge ignored", v, 16'h0);
          check("R6 clear drops irq", {15'h0, irq}, 16'h0);
        end

    // R6 partial clear and R8 enable masking
    pin_in[15:12] = 4'h0;
    wr(3'd4, 16'hF);
    wr(3'd3, 16'hF);
    wait_n(3);
    pin_in[15:12] = 4'hF;
    wait_n(4);
    rd(3'd5, v); check("R4 all four set", v, 16'h000F);
    wr(3'd5, 16'h0005);
    rd(3'd5, v); check("R6 write-1 clears, write-0 keeps", v, 16'h000A);
    wr(3'd3, 16'h0005);
    check("R8 irq low when set bits disabled", {15'h0, irq}, 16'h0);
    rd(3'd5, v); check("R8 status kept when disabled", v, 16'h000A);
    wr(3'd3, 16'h0002);
    check("R8 irq high when re-enabled", {15'h0, irq}, 16'h1);
    wr(3'd5, 16'hF);

    // R7 event and clear in the same cycle
    wr(3'd3, 16'h0001);
    wr(3'd4, 16'h0001);
    pin_in[12] = 0;
    wait_n(4);
    wr(3'd5, 16'hF);
    pin_in[12] = 1;
    wait_n(1);
    wr(3'd5, 16'h0001);
    rd(3'd5, v); check("R7 set wins over clear", v, 16'h0001);
    check("R7 irq stays high", {15'h0, irq}, 16'h1);
    wait_n(1);
    wr(3'd5, 16'h0001);
    rd(3'd5, v); check("R6 clear alone", v, 16'h0000);

    // R9 unused addresses
    rd(3'd6, v); check("R9 addr 6 reads zero", v, 16'h0);
    rd(3'd7, v); check("R9 addr 7 reads zero", v, 16'h0);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule